// File: doc/BRIEF.md
# Snoop Result Collector

This block sits next to main memory on a snooping bus that carries one transaction at a time. Each cache sends three reply bits for the transaction in flight. The bits say that the cache holds a copy, that its copy is dirty, and that its snoop is still running. The block merges each kind of reply across all caches into a registered bus-wide line.

While any cache is still snooping, the block holds memory back. The wait has no fixed length. Once every cache has finished, the block gives a one-cycle verdict:
- whether memory should supply the data, or stand aside because a cache owns the block;
- whether the requester may fill the line exclusive or only shared.

A watchdog counter raises an error flag if the snoop runs past a configured number of cycles. The transaction keeps waiting after the flag is raised.

Top module: `snoop_collect`

## Requirements
- R1: `any_shared`, `any_modified` and `any_pending` are the OR across all caches of `snp_copy`, `snp_dirty` and `snp_busy`. Each line shows the inputs as sampled at the previous rising clock edge, in every cycle.
- R2: A command is accepted on `cmd_valid` only when no transaction is being collected. A `cmd_valid` that arrives during collection is ignored and does not alter the verdict of the transaction in flight.
- R3: After a command is accepted, the verdict appears one cycle after the first rising edge at which no `snp_busy` bit is set. There is no upper bound on how long the block waits.
- R4: `result_valid` is a single-cycle pulse, one per accepted command. `mem_respond` and `mem_suppress` are asserted only together with it, and never both at once.
- R5: For a read (`cmd_op`=0) or a read-exclusive (`cmd_op`=1), `mem_respond` is 1 when no cache reports a dirty copy. When a dirty copy is reported, `mem_respond` is 0 and `mem_suppress` is 1.
- R6: With parameter `EXCL_SHARED_SUPPRESS`=1, a read-exclusive that sees a shared copy is withheld: `mem_respond`=0 and `mem_suppress`=1.
- R7: An upgrade (`cmd_op`=2) or a writeback (`cmd_op`=3) never asserts `mem_respond` or `mem_suppress`.
- R8: `grant_excl` is valid with `result_valid`:
  - for a read it is 1 only when neither a copy nor a dirty copy was reported;
  - for a read-exclusive or an upgrade it is 1;
  - for a writeback it is 0.
- R9: If `snp_busy` is seen at `WAIT_LIMIT` rising edges while a command is being collected, `snoop_timeout` goes to 1. It holds until the next command is accepted. Fewer busy edges never set it.
- R10: While `rst` is high and after it is released, all outputs are 0 until inputs arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A new bus command is present |
| cmd_op | input | 2 | Command: 0 read, 1 read-exclusive, 2 upgrade, 3 writeback |
| snp_copy | input | NUM_CACHES | Per-cache: holds a copy |
| snp_dirty | input | NUM_CACHES | Per-cache: holds a modified copy |
| snp_busy | input | NUM_CACHES | Per-cache: snoop not yet finished |
| any_shared | output | 1 | Registered OR of snp_copy |
| any_modified | output | 1 | Registered OR of snp_dirty |
| any_pending | output | 1 | Registered OR of snp_busy |
| result_valid | output | 1 | One-cycle verdict strobe |
| mem_respond | output | 1 | Memory supplies the data (pulse) |
| mem_suppress | output | 1 | Memory stands aside (pulse) |
| grant_excl | output | 1 | Fill exclusive (1) or shared (0) |
| snoop_timeout | output | 1 | Snoop exceeded WAIT_LIMIT busy cycles |

## Verification
The assertions assume the caches hold their copy and dirty bits steady once they drop busy, for the cycle in which the verdict is taken. They also assume that a new command is raised only after the previous verdict has been seen. The bench drives every command with an idle cycle on each side of the verdict. It presents the copy and dirty bits for the whole snoop window and changes them only after the verdict pulse. The one deliberate breach is a command injected during collection, which the block must discard.

// File: rtl/snoop_collect_pkg.sv
package snoop_collect_pkg;

    typedef enum logic [1:0] {
        OP_READ       = 2'd0,
        OP_READ_EXCL  = 2'd1,
        OP_UPGRADE    = 2'd2,
        OP_WRITEBACK  = 2'd3
    } bus_op_e;

    typedef struct packed {
        logic shared;
        logic modified;
        logic pending;
    } snoop_lines_t;

    typedef struct packed {
        logic respond;
        logic suppress;
        logic grant_excl;
    } mem_verdict_t;

    // Decide memory's role once every snoop has finished.
    function automatic mem_verdict_t decide_verdict(
        input bus_op_e      op,
        input snoop_lines_t lines,
        input logic         excl_shared_suppress
    );
        mem_verdict_t v;
        logic         wants_data;
        logic         withhold;
        wants_data = (op == OP_READ) || (op == OP_READ_EXCL);
        withhold   = lines.modified ||
                     ((op == OP_READ_EXCL) && lines.shared && excl_shared_suppress);
        v.respond    = wants_data && !withhold;
        v.suppress   = wants_data && withhold;
        case (op)
            OP_READ:      v.grant_excl = !lines.shared && !lines.modified;
            OP_READ_EXCL: v.grant_excl = 1'b1;
            OP_UPGRADE:   v.grant_excl = 1'b1;
            default:      v.grant_excl = 1'b0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/snoop_or_combiner.sv
module snoop_or_combiner
    import snoop_collect_pkg::*;
#(
    parameter int NUM_CACHES = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_CACHES-1:0] copy_in,
    input  logic [NUM_CACHES-1:0] dirty_in,
    input  logic [NUM_CACHES-1:0] busy_in,
    output snoop_lines_t          live_lines,
    output snoop_lines_t          held_lines
);

    logic [NUM_CACHES:0] acc_copy;
    logic [NUM_CACHES:0] acc_dirty;
    logic [NUM_CACHES:0] acc_busy;

    assign acc_copy[0]  = 1'b0;
    assign acc_dirty[0] = 1'b0;
    assign acc_busy[0]  = 1'b0;

    // One OR stage per cache, as a wired-OR line would merge them.
    for (genvar g = 0; g < NUM_CACHES; g++) begin : g_merge
        assign acc_copy[g+1]  = acc_copy[g]  | copy_in[g];
        assign acc_dirty[g+1] = acc_dirty[g] | dirty_in[g];
        assign acc_busy[g+1]  = acc_busy[g]  | busy_in[g];
    end

    assign live_lines.shared   = acc_copy[NUM_CACHES];
    assign live_lines.modified = acc_dirty[NUM_CACHES];
    assign live_lines.pending  = acc_busy[NUM_CACHES];

    always_ff @(posedge clk) begin
        if (rst) held_lines <= '0;
        else     held_lines <= live_lines;
    end

endmodule

// File: rtl/snoop_wait_timer.sv
module snoop_wait_timer #(
    parameter int WAIT_LIMIT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic active,
    input  logic busy,
    output logic timeout
);

    localparam int CNT_W = $clog2(WAIT_LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_LIMIT - 1);

    logic [CNT_W-1:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_cnt <= '0;
            timeout  <= 1'b0;
        end else if (start) begin
            busy_cnt <= '0;
            timeout  <= 1'b0;
        end else if (active && busy) begin
            if (busy_cnt == LAST) timeout  <= 1'b1;
            else                  busy_cnt <= busy_cnt + 1'b1;
        end
    end

    // R9: the flag never drops while a transaction is still collecting
    assert_timeout_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (timeout && !start) |=> timeout);

endmodule

// File: rtl/snoop_verdict_fsm.sv
module snoop_verdict_fsm
    import snoop_collect_pkg::*;
#(
    parameter bit EXCL_SHARED_SUPPRESS = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cmd_valid,
    input  bus_op_e      cmd_op,
    input  snoop_lines_t live_lines,
    output logic         accept,
    output logic         collecting,
    output logic         result_valid,
    output mem_verdict_t verdict
);

    typedef enum logic {ST_IDLE, ST_COLLECT} fsm_e;

    fsm_e         state;
    bus_op_e      held_op;
    mem_verdict_t next_verdict;

    assign accept       = (state == ST_IDLE) && cmd_valid;
    assign collecting   = (state == ST_COLLECT);
    assign next_verdict = decide_verdict(held_op, live_lines, EXCL_SHARED_SUPPRESS);

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            held_op      <= OP_READ;
            result_valid <= 1'b0;
            verdict      <= '0;
        end else begin
            result_valid <= 1'b0;
            verdict      <= '0;
            case (state)
                ST_IDLE: if (cmd_valid) begin
                    held_op <= cmd_op;
                    state   <= ST_COLLECT;
                end
                ST_COLLECT: if (!live_lines.pending) begin
                    result_valid <= 1'b1;
                    verdict      <= next_verdict;
                    state        <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R4: one verdict pulse, never repeated on the next cycle
    assert_single_verdict_R4: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> !result_valid);

    // R4: respond and suppress are mutually exclusive
    assert_resp_excl_R4: assert property (@(posedge clk) disable iff (rst)
        !(verdict.respond && verdict.suppress));

    // R7: writebacks and upgrades leave memory silent
    assert_quiet_ops_R7: assert property (@(posedge clk) disable iff (rst)
        (collecting && !live_lines.pending &&
         (held_op == OP_UPGRADE || held_op == OP_WRITEBACK))
        |=> (!verdict.respond && !verdict.suppress));

endmodule

// File: rtl/snoop_collect.sv
module snoop_collect
    import snoop_collect_pkg::*;
#(
    parameter int NUM_CACHES           = 4,
    parameter int WAIT_LIMIT           = 64,
    parameter bit EXCL_SHARED_SUPPRESS = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cmd_valid,
    input  logic [1:0]            cmd_op,
    input  logic [NUM_CACHES-1:0] snp_copy,
    input  logic [NUM_CACHES-1:0] snp_dirty,
    input  logic [NUM_CACHES-1:0] snp_busy,
    output logic                  any_shared,
    output logic                  any_modified,
    output logic                  any_pending,
    output logic                  result_valid,
    output logic                  mem_respond,
    output logic                  mem_suppress,
    output logic                  grant_excl,
    output logic                  snoop_timeout
);

    snoop_lines_t live_lines;
    snoop_lines_t held_lines;
    mem_verdict_t verdict;
    logic         accept;
    logic         collecting;

    snoop_or_combiner #(.NUM_CACHES(NUM_CACHES)) u_combine (
        .clk        (clk),
        .rst        (rst),
        .copy_in    (snp_copy),
        .dirty_in   (snp_dirty),
        .busy_in    (snp_busy),
        .live_lines (live_lines),
        .held_lines (held_lines)
    );

    snoop_verdict_fsm #(.EXCL_SHARED_SUPPRESS(EXCL_SHARED_SUPPRESS)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .cmd_valid    (cmd_valid),
        .cmd_op       (bus_op_e'(cmd_op)),
        .live_lines   (live_lines),
        .accept       (accept),
        .collecting   (collecting),
        .result_valid (result_valid),
        .verdict      (verdict)
    );

    snoop_wait_timer #(.WAIT_LIMIT(WAIT_LIMIT)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start   (accept),
        .active  (collecting),
        .busy    (live_lines.pending),
        .timeout (snoop_timeout)
    );

    assign any_shared   = held_lines.shared;
    assign any_modified = held_lines.modified;
    assign any_pending  = held_lines.pending;
    assign mem_respond  = verdict.respond;
    assign mem_suppress = verdict.suppress;
    assign grant_excl   = verdict.grant_excl;

    // R3: a verdict only appears once the pending line is clear
    assert_verdict_after_snoop_R3: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> !any_pending);

    // R5: memory never drives data over a modified copy
    assert_no_resp_on_dirty_R5: assert property (@(posedge clk) disable iff (rst)
        mem_respond |-> !any_modified);

    // R9: the timeout rises only while a snoop is still reported busy
    assert_timeout_when_busy_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(snoop_timeout) |-> any_pending);

    // R4: strobes only accompany the verdict pulse
    assert_strobe_with_valid_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_respond || mem_suppress) |-> result_valid);

endmodule

// File: tb/snoop_collect_bench.sv
module snoop_collect_bench;

    localparam int N     = 4;
    localparam int LIMIT = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic         cmd_valid;
    logic [1:0]   cmd_op;
    logic [N-1:0] snp_copy, snp_dirty, snp_busy;
    logic         any_shared, any_modified, any_pending;
    logic         result_valid, mem_respond, mem_suppress, grant_excl, snoop_timeout;

    int checks = 0;
    int errors = 0;

    // expected {respond, suppress, grant_excl, shared, modified}
    logic [4:0] expq[$];
    string      tagq[$];

    always #2 clk = ~clk;

    snoop_collect #(.NUM_CACHES(N), .WAIT_LIMIT(LIMIT), .EXCL_SHARED_SUPPRESS(1'b1)) u_snoop_collect (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .snp_copy(snp_copy), .snp_dirty(snp_dirty), .snp_busy(snp_busy),
        .any_shared(any_shared), .any_modified(any_modified), .any_pending(any_pending),
        .result_valid(result_valid), .mem_respond(mem_respond), .mem_suppress(mem_suppress),
        .grant_excl(grant_excl), .snoop_timeout(snoop_timeout)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard whenever a verdict appears.
    always @(negedge clk) begin
        if (!rst) begin
            if (result_valid) begin
                if (expq.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R4: unexpected verdict, actual 1 expected 0");
                end else begin
                    logic [4:0] e;
                    string      t;
                    e = expq.pop_front();
                    t = tagq.pop_front();
                    check({3'b0, mem_respond, mem_suppress, grant_excl, any_shared, any_modified},
                          {3'b0, e}, t);
                end
            end else if (mem_respond || mem_suppress) begin
                checks++; errors++;
                $display("FAIL R4: strobe without verdict, actual 1 expected 0");
            end
        end
    end

    // Driver: issues one command, holds busy for nbusy edges, pushes the expectation.
    task automatic txn(input logic [1:0] op, input logic [N-1:0] cp, input logic [N-1:0] dt,
                       input logic [N-1:0] bmask, input int nbusy, input bit inject,
                       input logic [4:0] exp, input string tag);
        expq.push_back(exp);
        tagq.push_back(tag);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'd0;
        snp_copy = cp; snp_dirty = dt;
        snp_busy = (nbusy > 0) ? bmask : '0;
        for (int i = 0; i < nbusy; i++) begin
            @(negedge clk);
            if (i == 0) begin
                check({7'b0, any_pending}, 8'd1, "R1 pending line");
                if (inject) begin cmd_valid = 1'b1; cmd_op = 2'd3; end
            end else begin
                cmd_valid = 1'b0; cmd_op = 2'd0;
            end
            if (i == 1) check({7'b0, result_valid}, 8'd0, "R3 held while busy");
        end
        cmd_valid = 1'b0;
        snp_busy = '0;
        @(negedge clk);
        snp_copy = '0; snp_dirty = '0;
        @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; cmd_valid = 1'b0; cmd_op = 2'd0;
        snp_copy = '0; snp_dirty = '0; snp_busy = '0;
        repeat (4) @(negedge clk);
        check({any_shared, any_modified, any_pending, result_valid, mem_respond,
               mem_suppress, grant_excl, snoop_timeout}, 8'd0, "R10 reset");
        rst = 1'b0;
        @(negedge clk);
        check({any_shared, any_modified, any_pending, result_valid, mem_respond,
               mem_suppress, grant_excl, snoop_timeout}, 8'd0, "R10 after reset");

        // exp = {respond, suppress, grant_excl, shared, modified}
        txn(2'd0, 4'b0000, 4'b0000, 4'b0000, 0, 0, 5'b10100, "R5 R8 read clean -> E");
        txn(2'd0, 4'b0100, 4'b0000, 4'b0001, 2, 0, 5'b10010, "R8 read shared -> S");
        txn(2'd0, 4'b1000, 4'b1000, 4'b1010, 3, 0, 5'b01011, "R5 read dirty suppressed");
        txn(2'd1, 4'b0000, 4'b0000, 4'b0000, 0, 0, 5'b10100, "R5 read-excl clean");
        txn(2'd1, 4'b0010, 4'b0000, 4'b0010, 1, 0, 5'b01110, "R6 read-excl shared withheld");
        txn(2'd1, 4'b0001, 4'b0001, 4'b0000, 0, 0, 5'b01111, "R5 read-excl dirty");
        txn(2'd2, 4'b0110, 4'b0000, 4'b0100, 2, 0, 5'b00110, "R7 R8 upgrade");
        txn(2'd3, 4'b0000, 4'b0000, 4'b0000, 0, 0, 5'b00000, "R7 R8 writeback");
        txn(2'd0, 4'b0000, 4'b0000, 4'b1111, 3, 1, 5'b10100, "R2 injected cmd ignored");

        txn(2'd0, 4'b0000, 4'b0000, 4'b0001, LIMIT - 1, 0, 5'b10100, "R3 long snoop");
        check({7'b0, snoop_timeout}, 8'd0, "R9 below limit");
        txn(2'd0, 4'b0010, 4'b0000, 4'b0010, LIMIT, 0, 5'b10010, "R3 R9 snoop at limit");
        check({7'b0, snoop_timeout}, 8'd1, "R9 timeout set");
        repeat (3) @(negedge clk);
        check({7'b0, snoop_timeout}, 8'd1, "R9 timeout held");
        txn(2'd3, 4'b0000, 4'b0000, 4'b0000, 0, 0, 5'b00000, "R7 writeback after timeout");
        check({7'b0, snoop_timeout}, 8'd0, "R9 cleared by next command");

        // R1: lines follow inputs even outside a transaction
        snp_copy = 4'b0100; snp_dirty = 4'b0000; snp_busy = 4'b0010;
        @(negedge clk);
        check({5'b0, any_shared, any_modified, any_pending}, 8'b101, "R1 idle lines");
        snp_copy = '0; snp_busy = '0;
        @(negedge clk);
        check({5'b0, any_shared, any_modified, any_pending}, 8'b000, "R1 lines clear");
        check({7'b0, result_valid}, 8'd0, "R2 no command no verdict");

        repeat (3) @(negedge clk);
        checks++;
        if (expq.size() != 0) begin
            errors++;
            $display("FAIL R4: missing verdicts, actual %0d expected 0", expq.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule